// File: doc/BRIEF.md
# Reset source controller with cause flags

This block merges several reset requests into one synchronous system reset and records which request caused it. It takes a power-on reset (the asynchronous `rst_ni`), an active-low external reset pin, a supply comparator output, and a one-cycle missing-clock timeout pulse. Any request it accepts drives `sys_rst_o` high. The output then stays high for a fixed stretch after the last request goes away.

A byte-wide register port, with address, write strobe and read strobe, gives access to two registers. The supply control register sits at address 0xFF. The cause register sits at parameter `SRC_ADDR`, default 0xEF. The cause register holds one-hot flags on reads. On writes it takes the per-source enables for the missing-clock and supply requests. The supply monitor enable survives every reset except power-on. The monitor can only force a reset once it is also selected in the cause register.

Top module: `rstc_top`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is high. After release, the cause register reads 0x02 (power-on flag, bit 1), the supply enable (0xFF bit 7) reads 1, and both source selects are 0.
- R2: `sys_rst_o` stays high for exactly `STRETCH` clock edges after the last edge at which a request was active.
- R3: The pin passes through a two-flop synchronizer. It forces a reset only after `FILT` consecutive low samples, so a low pulse shorter than `FILT` cycles has no effect.
- R4: After a pin reset, the cause register reads 0x01 (bit 0).
- R5: A missing-clock pulse forces a reset only when cause-register bit 2 has been written 1. After that reset the cause register reads 0x04.
- R6: A supply comparator at 0 (at or below threshold) with the enable set forces no reset until cause-register bit 3 is written 1. It then forces a reset, and the cause register reads 0x08.
- R7: With 0xFF bit 7 written 0, a low supply forces no reset even when bit 3 is selected.
- R8: 0xFF bit 7 keeps its value through pin, supply and missing-clock resets. Power-on sets it back to 1.
- R9: 0xFF bit 6 reads the synchronized comparator: 1 above threshold, 0 at or below. Writes to bit 6 are ignored. Bits 5:0 read 0, and an unmapped address reads 0x00.
- R10: The cause register always holds exactly one flag. When requests coincide on one edge, pin wins over supply, and supply wins over missing-clock.
- R11: Any reset clears both source selects. Register writes made while `sys_rst_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| vdd_ok_i | input | 1 | Supply comparator, 1 = above threshold |
| mcd_timeout_i | input | 1 | Missing-clock timeout pulse, synchronous |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe; read data is combinational |
| reg_rdata_o | output | 8 | Read data, 0 when reg_re_i is low |
| sys_rst_o | output | 1 | Synchronous system reset, active high |

## Verification
The bench builds the block with `FILT`=3 and `STRETCH`=6. With these values every pin pulse width from 1 to 6 cycles can be swept, covering both sides of the filter threshold. The exact stretch length can also be counted sample by sample. Each source, each enable combination and the supply-over-missing-clock tie all reach reset within a few dozen cycles. The stickiness of the supply enable is exercised against both power-on and non-power-on resets.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int FLG_PIN = 0;
  localparam int FLG_POR = 1;
  localparam int FLG_MCD = 2;
  localparam int FLG_SUP = 3;
  localparam int NFLG    = 4;
  localparam logic [7:0] SUP_CTRL_ADDR = 8'hFF;
  localparam int MON_EN_BIT = 7;
  localparam int STAT_BIT   = 6;
  typedef logic [NFLG-1:0] flags_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int FILT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic req_o
);
  localparam int FW = $clog2(FILT + 1);
  localparam logic [FW-1:0] FMAX = FW'(FILT);

  logic pin_s;
  logic [FW-1:0] fcnt_q;

  rstc_sync #(.W(1), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_ni), .q_o(pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fcnt_q <= '0;
    else if (pin_s)       fcnt_q <= '0;
    else if (fcnt_q != FMAX) fcnt_q <= fcnt_q + 1'b1;
  end

  assign req_o = (fcnt_q == FMAX);

  // R3: a request needs the previous synchronized sample low
  a_r3_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(!pin_s));
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rst_o
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] CMAX = CW'(STRETCH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CMAX;
    else if (req_i)       cnt_q <= CMAX;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o = (cnt_q != '0);

  a_r2_req_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rst_o);
  a_r2_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !rst_o) |=> !rst_o);
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int         STRETCH  = 8,
  parameter int         FILT     = 3,
  parameter logic [7:0] SRC_ADDR = 8'hEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       vdd_ok_i,
  input  logic       mcd_timeout_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  output logic [7:0] reg_rdata_o,
  output logic       sys_rst_o
);
  logic pin_req, sup_req, mcd_req, any_req, vdd_s;
  logic mon_en_q, sup_sel_q, mcd_en_q;
  flags_t flags_q, flags_nxt;

  rstc_pin_filter #(.FILT(FILT)) i_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(ext_rst_ni), .req_o(pin_req)
  );

  rstc_sync #(.W(1), .RST_VAL(1'b1)) i_vdd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vdd_ok_i), .q_o(vdd_s)
  );

  assign sup_req = mon_en_q & sup_sel_q & ~vdd_s;
  assign mcd_req = mcd_en_q & mcd_timeout_i;
  assign any_req = pin_req | sup_req | mcd_req;

  rstc_stretch #(.STRETCH(STRETCH)) i_stretch (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(any_req), .rst_o(sys_rst_o)
  );

  // fixed priority: pin, supply, missing clock
  always_comb begin
    flags_nxt = '0;
    if (pin_req)      flags_nxt[FLG_PIN] = 1'b1;
    else if (sup_req) flags_nxt[FLG_SUP] = 1'b1;
    else              flags_nxt[FLG_MCD] = 1'b1;
  end

  logic wr_ok;
  assign wr_ok = reg_we_i & ~sys_rst_o & ~any_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_en_q  <= 1'b1;
      sup_sel_q <= 1'b0;
      mcd_en_q  <= 1'b0;
      flags_q   <= flags_t'(1 << FLG_POR);
    end else begin
      if (any_req) flags_q <= flags_nxt;
      if (sys_rst_o || any_req) begin
        sup_sel_q <= 1'b0;
        mcd_en_q  <= 1'b0;
      end else if (wr_ok) begin
        if (reg_addr_i == SUP_CTRL_ADDR) mon_en_q <= reg_wdata_i[MON_EN_BIT];
        if (reg_addr_i == SRC_ADDR) begin
          mcd_en_q  <= reg_wdata_i[FLG_MCD];
          sup_sel_q <= reg_wdata_i[FLG_SUP];
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      if (reg_addr_i == SUP_CTRL_ADDR) begin
        reg_rdata_o[MON_EN_BIT] = mon_en_q;
        reg_rdata_o[STAT_BIT]   = vdd_s;
      end else if (reg_addr_i == SRC_ADDR) begin
        reg_rdata_o[NFLG-1:0] = flags_q;
      end
    end
  end

  a_r10_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags_q) == 1);
  a_r8_mon_en_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> $stable(mon_en_q));
  a_r11_sel_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> (!sup_sel_q && !mcd_en_q));
  a_r6_sel_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_o && !pin_req && !mcd_req && !sup_sel_q) |=> !sys_rst_o);
endmodule

// File: tb/test_rstc_top.sv
module test_rstc_top;
  localparam int S = 6;
  localparam int F = 3;
  localparam logic [7:0] SRC = 8'hEF;

  logic clk = 0, rst_n = 0, pin_n = 1, vdd = 1, mcd = 0, we = 0, re = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic sys_rst;
  int checks = 0, fails = 0;
  logic done = 0;

  always #5 clk = ~clk;

  rstc_top #(.STRETCH(S), .FILT(F), .SRC_ADDR(SRC)) i_rstc_top (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(pin_n), .vdd_ok_i(vdd),
    .mcd_timeout_i(mcd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_re_i(re), .reg_rdata_o(rdata), .sys_rst_o(sys_rst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; re = 1; #1; d = rdata; re = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1; tick(1); we = 0;
  endtask

  // counts samples with sys_rst high over n cycles
  task automatic watch(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (sys_rst) hi++;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && sys_rst; i++) tick(1);
  endtask

  task automatic por();
    rst_n = 0; tick(2); rst_n = 1;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int hi;
    tick(2);
    chk(sys_rst == 1, "R1 reset held", sys_rst, 1);
    rst_n = 1;
    watch(20, hi);
    chk(hi == S - 1, "R2 stretch length", hi, S - 1);
    rd(SRC, d);     chk(d == 8'h02, "R1 por flag", d, 8'h02);
    rd(8'hFF, d);   chk(d == 8'hC0, "R1/R9 ctrl default", d, 8'hC0);
    rd(8'h10, d);   chk(d == 8'h00, "R9 unmapped", d, 0);

    // R9 status and write masking
    wr(8'hFF, 8'h00); rd(8'hFF, d); chk(d == 8'h40, "R9 bit6 ignores write", d, 8'h40);
    wr(8'hFF, 8'hBF); rd(8'hFF, d); chk(d == 8'hC0, "R9 low bits zero", d, 8'hC0);
    vdd = 0; tick(3); rd(8'hFF, d); chk(d == 8'h80, "R9 status low", d, 8'h80);
    vdd = 1; tick(3);

    // R3/R4 pulse width sweep
    for (int w = 1; w <= 6; w++) begin
      pin_n = 0; tick(w); pin_n = 1;
      watch(8, hi);
      chk((hi > 0) == (w >= F), $sformatf("R3 width %0d", w), hi > 0, w >= F);
      wait_idle(); tick(2);
      if (w >= F) begin
        rd(SRC, d); chk(d == 8'h01, "R4 pin flag", d, 8'h01);
      end
    end

    // R5 missing clock
    mcd = 1; tick(1); mcd = 0; watch(4, hi);
    chk(hi == 0, "R5 disabled ignored", hi, 0);
    wr(SRC, 8'h04); mcd = 1; tick(1); mcd = 0; watch(4, hi);
    chk(hi > 0, "R5 enabled resets", hi, 1);
    wait_idle(); rd(SRC, d); chk(d == 8'h04, "R5 mcd flag", d, 8'h04);
    mcd = 1; tick(1); mcd = 0; watch(4, hi);
    chk(hi == 0, "R11 mcd select cleared", hi, 0);

    // R6 supply gating
    vdd = 0; watch(10, hi); chk(hi == 0, "R6 unselected no reset", hi, 0);
    wr(SRC, 8'h08); watch(4, hi); chk(hi > 0, "R6 selected resets", hi, 1);
    wait_idle(); tick(2);
    chk(sys_rst == 0, "R11 supply reset ends", sys_rst, 0);
    rd(SRC, d); chk(d == 8'h08, "R6 sup flag", d, 8'h08);
    vdd = 1; tick(3);

    // R7 enable off
    wr(8'hFF, 8'h00); vdd = 0; tick(3); wr(SRC, 8'h08); watch(10, hi);
    chk(hi == 0, "R7 monitor off", hi, 0);
    vdd = 1; tick(3);

    // R8 stickiness
    pin_n = 0; tick(5); pin_n = 1; wait_idle(); tick(2);
    rd(8'hFF, d); chk(d[7] == 0, "R8 sticky through pin", d[7], 0);
    por(); wait_idle(); tick(3);
    rd(8'hFF, d); chk(d[7] == 1, "R8 por sets enable", d[7], 1);

    // R10 coinciding supply and missing clock
    vdd = 0; tick(4);
    addr = SRC; wdata = 8'h0C; we = 1; tick(1); we = 0; mcd = 1; tick(1); mcd = 0;
    wait_idle(); tick(2);
    rd(SRC, d); chk(d == 8'h08, "R10 supply over mcd", d, 8'h08);
    vdd = 1; tick(3);

    // R11 write during reset ignored
    pin_n = 0; tick(6);
    chk(sys_rst == 1, "R3 long low held", sys_rst, 1);
    wr(8'hFF, 8'h00); pin_n = 1; wait_idle(); tick(2);
    rd(8'hFF, d); chk(d[7] == 1, "R11 write in reset ignored", d[7], 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule